// File: doc/BRIEF.md
# Line-Burst SDRAM Write Controller

This controller stores a line-synchronised pixel stream in a single-bank SDRAM. Each incoming line goes to its own row as one full-page write burst. Between lines the stream is silent, and the controller uses that silence to issue a fixed number of auto-refresh commands. Because refresh never competes with pixel traffic, no pixel bandwidth is spent on it. A neighbouring buffer-switch block watches the one-cycle line-complete pulse and the idle flag, and uses them to decide when to swap memories.

After reset the controller keeps the memory deselected until a start pulse arrives. The start pulse runs a short fixed power-up sequence. From then on, every line sync opens a row, streams the pixels, terminates the burst, closes the row and refreshes a batch of rows. A rotating refresh-row counter cycles through the 4096 rows. With 20 refreshes per gap, every row is covered in about 205 lines, or about 2.5 ms at 100 MHz, which is far inside the 64 ms retention window.

Top module: `line_burst_writer`

## Requirements
- R1: After reset and before a start pulse, {cs_n,ras_n,cas_n,we_n} is 1111, the address, data, line-done and idle outputs are 0, and a line sync has no effect.
- R2: A start pulse produces a precharge-all with address bit 10 set. TRP cycles later comes the first of INIT_REFS refresh commands spaced TRFC cycles apart, with address 0. TRFC cycles after the last of these comes a mode load with address 0x027, which selects full-page bursts and read latency 2. idle_o rises TMRD cycles after the mode load.
- R3: The command pins {cs_n,ras_n,cas_n,we_n} use these codes: NOP 0111, ACTIVATE 0011, WRITE 0100, BURST TERMINATE 0110, PRECHARGE 0010, REFRESH 0001, MODE LOAD 0000. A sync sampled while idle gives an ACTIVATE in the next cycle. WRITE follows TRCD cycles after ACTIVATE, with address 0.
- R4: The pixel driven TRCD cycles after the sync cycle appears on the data output together with WRITE. The next LINE_PIX-1 cycles carry the following pixels, one per cycle. The data output is 0 in every other cycle.
- R5: The cycle after the last word carries BURST TERMINATE. The cycle after that carries PRECHARGE with address bit 10 set.
- R6: TRP cycles after that PRECHARGE, the first gap refresh is issued. line_done_o is high in that cycle only.
- R7: Each gap holds exactly REF_PER_GAP refreshes, TRFC cycles apart. The address of each refresh is the refresh-row counter, which starts at 0, advances by one per gap refresh and wraps from 4095 to 0.
- R8: idle_o rises TRFC cycles after the last gap refresh. Only NOP appears between the last refresh and the next ACTIVATE.
- R9: The ACTIVATE address is the line row. The line row starts at 0, rises by one per completed line and wraps from 4095 to 0.
- R10: A sync or start pulse sampled while a line or its refresh gap is in progress, or a start pulse sampled after initialisation, leaves the command stream unchanged.
- R11: Reset asserted in the middle of a line returns the outputs to the R1 state. After a new start, both row counters begin again at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that runs the power-up sequence |
| line_sync_i | input | 1 | One-cycle pulse announcing a line |
| pix_i | input | DATA_W | Pixel word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row, column or mode address |
| sd_dq | output | DATA_W | Write data |
| line_done_o | output | 1 | One-cycle pulse once the row is closed |
| idle_o | output | 1 | High while waiting for a sync |

## Verification
The hardest states to reach are the wrap of the refresh-row counter and the wrap of the line row. These only occur after thousands of refreshes and 4096 lines. The bench therefore shrinks the line length and the number of refreshes per gap, keeps the row width at full size, and streams more than 4096 back-to-back lines. Every cycle of every line is checked. Sync and start pulses are also injected during the burst and during the refresh gap, to show that they are ignored.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
    typedef enum logic [2:0] {
        CMD_INH, CMD_NOP, CMD_ACT, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
    } lbw_cmd_e;

    typedef enum logic [3:0] {
        S_OFF, S_IPRE, S_IREF, S_IMRS, S_IDLE, S_ACT, S_WR, S_BST, S_PRE, S_REF
    } lbw_state_e;
endpackage

// File: rtl/lbw_wrap_ctr.sv
module lbw_wrap_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (inc_i) val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    // R7
    wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (val_q == $past(val_q) + 1'b1));
endmodule

// File: rtl/lbw_cmd_pins.sv
module lbw_cmd_pins
    import lbw_pkg::*;
(
    input  lbw_cmd_e cmd_i,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);
    always_comb begin
        case (cmd_i)
            CMD_NOP: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_ACT: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            CMD_WR:  {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            CMD_BST: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_MRS: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    end
endmodule

// File: rtl/lbw_seq.sv
module lbw_seq
    import lbw_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ROW_W       = 12,
    parameter int LINE_PIX    = 1024,
    parameter int TRCD        = 2,
    parameter int TRP         = 2,
    parameter int TRFC        = 8,
    parameter int TMRD        = 2,
    parameter int REF_PER_GAP = 20,
    parameter int INIT_REFS   = 2,
    parameter int CNT_W       = 11,
    parameter int RN_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sync_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic [ROW_W-1:0]  line_row_i,
    input  logic [ROW_W-1:0]  ref_row_i,
    output lbw_cmd_e          cmd_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              line_done_o,
    output logic              idle_o,
    output logic              line_inc_o,
    output logic              ref_inc_o
);
    localparam logic [ROW_W-1:0] PRE_ALL   = ROW_W'(1) << 10;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(12'h027);

    typedef struct packed {
        lbw_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [RN_W-1:0]   refn;
        lbw_cmd_e          cmd;
        logic [ROW_W-1:0]  addr;
        logic [DATA_W-1:0] dq;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;
    logic  line_inc_d, ref_inc_d;
    logic  wait_busy;

    assign wait_busy = (r_q.cnt != '0);

    always_comb begin
        r_d        = r_q;
        r_d.cmd    = CMD_NOP;
        r_d.addr   = '0;
        r_d.dq     = '0;
        r_d.done   = 1'b0;
        line_inc_d = 1'b0;
        ref_inc_d  = 1'b0;
        if (wait_busy) r_d.cnt = r_q.cnt - 1'b1;
        case (r_q.state)
            S_OFF: begin
                r_d.cmd = CMD_INH;
                if (start_i) begin
                    r_d.state = S_IPRE;
                    r_d.cmd   = CMD_PRE;
                    r_d.addr  = PRE_ALL;
                    r_d.cnt   = CNT_W'(TRP - 1);
                end
            end
            S_IPRE: if (!wait_busy) begin
                r_d.state = S_IREF;
                r_d.cmd   = CMD_REF;
                r_d.cnt   = CNT_W'(TRFC - 1);
                r_d.refn  = RN_W'(1);
            end
            S_IREF: if (!wait_busy) begin
                if (r_q.refn == RN_W'(INIT_REFS)) begin
                    r_d.state = S_IMRS;
                    r_d.cmd   = CMD_MRS;
                    r_d.addr  = MODE_WORD;
                    r_d.cnt   = CNT_W'(TMRD - 1);
                end else begin
                    r_d.cmd   = CMD_REF;
                    r_d.cnt   = CNT_W'(TRFC - 1);
                    r_d.refn  = r_q.refn + 1'b1;
                end
            end
            S_IMRS: if (!wait_busy) r_d.state = S_IDLE;
            S_IDLE: if (sync_i) begin
                r_d.state = S_ACT;
                r_d.cmd   = CMD_ACT;
                r_d.addr  = line_row_i;
                r_d.cnt   = CNT_W'(TRCD - 1);
            end
            S_ACT: if (!wait_busy) begin
                r_d.state = S_WR;
                r_d.cmd   = CMD_WR;
                r_d.dq    = pix_i;
                r_d.cnt   = CNT_W'(LINE_PIX - 1);
            end
            S_WR: begin
                if (wait_busy) begin
                    r_d.dq = pix_i;
                end else begin
                    r_d.state = S_BST;
                    r_d.cmd   = CMD_BST;
                end
            end
            S_BST: begin
                r_d.state = S_PRE;
                r_d.cmd   = CMD_PRE;
                r_d.addr  = PRE_ALL;
                r_d.cnt   = CNT_W'(TRP - 1);
            end
            S_PRE: if (!wait_busy) begin
                r_d.state  = S_REF;
                r_d.cmd    = CMD_REF;
                r_d.addr   = ref_row_i;
                r_d.cnt    = CNT_W'(TRFC - 1);
                r_d.refn   = RN_W'(1);
                r_d.done   = 1'b1;
                line_inc_d = 1'b1;
                ref_inc_d  = 1'b1;
            end
            S_REF: if (!wait_busy) begin
                if (r_q.refn == RN_W'(REF_PER_GAP)) begin
                    r_d.state = S_IDLE;
                end else begin
                    r_d.cmd   = CMD_REF;
                    r_d.addr  = ref_row_i;
                    r_d.cnt   = CNT_W'(TRFC - 1);
                    r_d.refn  = r_q.refn + 1'b1;
                    ref_inc_d = 1'b1;
                end
            end
            default: r_d.state = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_OFF;
            r_q.cmd   <= CMD_INH;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o       = r_q.cmd;
    assign addr_o      = r_q.addr;
    assign dq_o        = r_q.dq;
    assign line_done_o = r_q.done;
    assign idle_o      = (r_q.state == S_IDLE);
    assign line_inc_o  = line_inc_d;
    assign ref_inc_o   = ref_inc_d;

    // R1
    off_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_OFF) |-> (r_q.cmd == CMD_INH));
    // R3
    sync_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE && sync_i) |=> (r_q.cmd == CMD_ACT));
    // R10
    act_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_ACT) |-> ($past(r_q.state) == S_IDLE));
    // R5
    bst_then_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_BST) |=> (r_q.cmd == CMD_PRE));
    // R6
    done_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.cmd == CMD_REF && $past(r_q.state) == S_PRE));
    // R4
    data_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.dq != '0) |-> (r_q.state == S_WR));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE) |-> (r_q.cmd == CMD_NOP));
endmodule

// File: rtl/line_burst_writer.sv
module line_burst_writer
    import lbw_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ROW_W       = 12,
    parameter int LINE_PIX    = 1024,
    parameter int TRCD        = 2,
    parameter int TRP         = 2,
    parameter int TRFC        = 8,
    parameter int TMRD        = 2,
    parameter int REF_PER_GAP = 20,
    parameter int INIT_REFS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              line_sync_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq,
    output logic              line_done_o,
    output logic              idle_o
);
    localparam int CNT_W = $clog2(LINE_PIX + TRFC + TRP + TRCD + TMRD + 1);
    localparam int RN_W  = $clog2(REF_PER_GAP + INIT_REFS + 1);

    lbw_cmd_e         cmd;
    logic             line_inc, ref_inc;
    logic [ROW_W-1:0] line_row, ref_row;

    lbw_wrap_ctr #(.W(ROW_W)) line_ctr_i (
        .clk(clk), .rst_n(rst_n), .inc_i(line_inc), .val_o(line_row));

    lbw_wrap_ctr #(.W(ROW_W)) ref_ctr_i (
        .clk(clk), .rst_n(rst_n), .inc_i(ref_inc), .val_o(ref_row));

    lbw_seq #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .LINE_PIX(LINE_PIX), .TRCD(TRCD),
        .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .REF_PER_GAP(REF_PER_GAP),
        .INIT_REFS(INIT_REFS), .CNT_W(CNT_W), .RN_W(RN_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sync_i(line_sync_i),
        .pix_i(pix_i), .line_row_i(line_row), .ref_row_i(ref_row),
        .cmd_o(cmd), .addr_o(sd_addr), .dq_o(sd_dq),
        .line_done_o(line_done_o), .idle_o(idle_o),
        .line_inc_o(line_inc), .ref_inc_o(ref_inc));

    lbw_cmd_pins pins_i (
        .cmd_i(cmd), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
        .cas_n(sd_cas_n), .we_n(sd_we_n));

    // R9
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> (line_row == $past(line_row) + 1'b1));
endmodule

// File: tb/line_burst_writer_tb_top.sv
module line_burst_writer_tb_top;
    localparam int DW = 16, RW = 12, LP = 8, TRCD = 2, TRP = 2, TRFC = 4;
    localparam int TMRD = 2, RPG = 3, IREF = 2;
    localparam logic [3:0] P_INH = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
        P_WR = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010, P_REF = 4'b0001,
        P_MRS = 4'b0000;
    // vector: seed[15:0], gap[3:0], dup[1:0] (0 none, 1 sync in burst, 2 sync in refresh, 3 start in burst)
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {16'h1234, 4'd0, 2'd0}, {16'hA5A5, 4'd3, 2'd1}, {16'h0001, 4'd1, 2'd2},
        {16'hFF00, 4'd5, 2'd3}, {16'h7E7E, 4'd0, 2'd0}, {16'hC3C3, 4'd2, 2'd1}};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sync = 1'b0;
    logic [DW-1:0] pix = '0;
    logic cs_n, ras_n, cas_n, we_n, done, idle;
    logic [RW-1:0] addr;
    logic [DW-1:0] dq;
    int n_chk = 0, n_fail = 0;
    logic [RW-1:0] exp_row = '0, exp_ref = '0;

    always #2 clk = ~clk;

    line_burst_writer #(.DATA_W(DW), .ROW_W(RW), .LINE_PIX(LP), .TRCD(TRCD),
        .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .REF_PER_GAP(RPG), .INIT_REFS(IREF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .line_sync_i(sync), .pix_i(pix),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(addr), .sd_dq(dq), .line_done_o(done), .idle_o(idle));

    task automatic chk(input string tag, input logic [3:0] ep, input logic [RW-1:0] ea,
                       input logic [DW-1:0] ed, input logic edn, input logic eid);
        logic [33:0] got, exp;
        got = {cs_n, ras_n, cas_n, we_n, addr, dq, done, idle};
        exp = {ep, ea, ed, edn, eid};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got pins=%b addr=%h dq=%h done=%b idle=%b, expected pins=%b addr=%h dq=%h done=%b idle=%b",
                     tag, got[33:30], got[29:18], got[17:2], got[1], got[0],
                     ep, ea, ed, edn, eid);
        end
    endtask

    function automatic logic [DW-1:0] pixel(input logic [DW-1:0] seed, input int k);
        return seed + DW'(k) * 16'h0101;
    endfunction

    task automatic run_init();
        int i_mrs = 1 + TRP + IREF * TRFC;
        @(negedge clk); start = 1'b1;
        for (int i = 1; i <= i_mrs + TMRD; i++) begin
            @(negedge clk); start = 1'b0;
            if (i == 1) chk("R2 precharge-all", P_PRE, 12'h400, '0, 1'b0, 1'b0);
            else if (i >= 1 + TRP && i < i_mrs && (i - 1 - TRP) % TRFC == 0)
                chk("R2 init refresh", P_REF, '0, '0, 1'b0, 1'b0);
            else if (i == i_mrs) chk("R2 mode load", P_MRS, 12'h027, '0, 1'b0, 1'b0);
            else if (i == i_mrs + TMRD) chk("R2 idle after init", P_NOP, '0, '0, 1'b0, 1'b1);
            else chk("R2 init wait", P_NOP, '0, '0, 1'b0, 1'b0);
        end
    endtask

    task automatic run_line(input logic [DW-1:0] seed, input int gap, input int dup);
        int i_wr = TRCD + 1;
        int i_bst = i_wr + LP;
        int i_pre = i_bst + 1;
        int i_ref0 = i_pre + TRP;
        int i_end = i_ref0 + RPG * TRFC;
        int n = 0;
        string tg;
        while (!idle && n < 200) begin @(negedge clk); n++; end
        repeat (gap) begin
            @(negedge clk);
            chk("R8 idle gap", P_NOP, '0, '0, 1'b0, 1'b1);
        end
        sync = 1'b1; pix = ~seed;
        for (int i = 1; i <= i_end; i++) begin
            @(negedge clk);
            sync = 1'b0; start = 1'b0;
            if (i == 1) begin tg = "R3 R9 activate"; chk(tg, P_ACT, exp_row, '0, 1'b0, 1'b0); end
            else if (i == i_wr) chk(dup != 0 ? "R10 write" : "R3 R4 write", P_WR, '0, pixel(seed, 0), 1'b0, 1'b0);
            else if (i > i_wr && i < i_bst) chk(dup != 0 ? "R10 burst" : "R4 burst", P_NOP, '0, pixel(seed, i - i_wr), 1'b0, 1'b0);
            else if (i == i_bst) chk("R5 terminate", P_BST, '0, '0, 1'b0, 1'b0);
            else if (i == i_pre) chk("R5 precharge", P_PRE, 12'h400, '0, 1'b0, 1'b0);
            else if (i == i_ref0) chk("R6 first refresh", P_REF, exp_ref, '0, 1'b1, 1'b0);
            else if (i > i_ref0 && i < i_end && (i - i_ref0) % TRFC == 0)
                chk(dup != 0 ? "R10 refresh" : "R7 refresh", P_REF, exp_ref + RW'((i - i_ref0) / TRFC), '0, 1'b0, 1'b0);
            else if (i == i_end) chk("R8 back to idle", P_NOP, '0, '0, 1'b0, 1'b1);
            else chk("R7 R8 wait", P_NOP, '0, '0, 1'b0, 1'b0);
            pix = (i >= TRCD && i - TRCD < LP) ? pixel(seed, i - TRCD) : ~seed;
            if (dup == 1 && i == TRCD + 3) sync = 1'b1;
            if (dup == 2 && i == i_ref0 + 1) sync = 1'b1;
            if (dup == 3 && i == TRCD + 2) start = 1'b1;
        end
        exp_row = exp_row + 1'b1;
        exp_ref = exp_ref + RW'(RPG);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state and sync before start
        repeat (3) @(negedge clk);
        chk("R1 in reset", P_INH, '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sync = (i == 2);
            @(negedge clk);
            sync = 1'b0;
            chk("R1 before start", P_INH, '0, '0, 1'b0, 1'b0);
        end
        run_init();
        // table walk
        for (int v = 0; v < NVEC; v++)
            run_line(VEC[v][21:6], int'(VEC[v][5:2]), int'(VEC[v][1:0]));
        // R10: start after init, while idle
        @(negedge clk); start = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); start = 1'b0;
            chk("R10 start when idle", P_NOP, '0, '0, 1'b0, 1'b1);
        end
        // R7 R9: long run past both wraps (refresh row at 4095, line row at 4095)
        for (int l = 0; l < 4100; l++) run_line(DW'(l * 7 + 3), 0, 0);
        // R11: reset in the middle of a burst
        @(negedge clk); sync = 1'b1;
        repeat (TRCD + 3) @(negedge clk);
        sync = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset mid-line", P_INH, '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", P_INH, '0, '0, 1'b0, 1'b0);
        exp_row = '0; exp_ref = '0;
        run_init();
        run_line(16'h5A5A, 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule